// File: doc/BRIEF.md
# Multi-hit TDC hit recorder

This block time-stamps rising edges on 24 digital channels and keeps the results in one hit buffer that all channels share. A free-running coarse counter supplies the upper bits of each time. A per-channel 5-bit interpolation code, taken from the block's inputs, supplies the lower bits. Together they form a 17-bit stamp with 32 fine steps per clock period. Each recorded hit is stored with its channel number. A channel keeps at most 16 hits per event. When the shared buffer is full, a mode input picks the policy: either the oldest hit is dropped, or the new hit is refused and a sticky overflow flag is raised.

A trigger pulse freezes recording and starts a readout. The buffer is drained from oldest to newest. Only hits whose stamp falls within a programmable look-back window before the trigger time are presented on a valid/ready word port. The readout ends with a trailer word that carries the number of hits sent and the overflow flag. Once the trailer is taken, a new event begins.

Top module: `tdc_hit_recorder`

## Requirements
- R1: After reset the outputs `out_valid` and `busy` are low and the buffer is empty, so a trigger with the widest window yields only a trailer with count 0.
- R2: While `enable` is low, rising edges on `hit_in` are not recorded.
- R3: A data word holds the overflow bit in [22], the channel number in [21:17] and the stamp in [16:0]. The stamp's low 5 bits equal that channel's `fine_in` code when the edge was seen.
- R4: Hits seen on several channels in the same cycle are stored, and read out, in ascending channel order.
- R5: A channel records at most 16 hits per event. Further edges on that channel are dropped.
- R6: With `mode_fifo` low and 256 words stored, new hits are refused, the stored hits are kept, and trailer bit [22] reads 1.
- R7: With `mode_fifo` high and 256 words stored, each new hit discards the oldest one and is stored with its overflow bit [22] set. Trailer bit [22] stays 0.
- R8: A trigger latches the time T = {coarse, 5'h1F}. Only hits with (T − stamp) mod 2^17 ≤ `window` are emitted, and the others are discarded. No hit is stored while `busy` is high.
- R9: A readout ends with one word that has `out_last` high and the count of emitted hits in bits [8:0], after which `busy` falls.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_word` hold their values.
- R11: After the trailer is accepted, the buffer is empty and the per-channel counts and the overflow flag are cleared.
- R12: Two hits on one channel N cycles apart with the same fine code have stamps that differ by N·32, modulo 2^17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock; one coarse tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Allows hits to be recorded |
| mode_fifo | input | 1 | 1: drop the oldest hit when full; 0: refuse new hits and flag |
| hit_in | input | 24 | Asynchronous hit inputs, one per channel |
| fine_in | input | 120 | 5-bit interpolation code per channel, channel c at [5c+4:5c] |
| trig | input | 1 | Trigger pulse that starts a readout |
| window | input | 17 | Look-back window in fine LSBs |
| out_ready | input | 1 | Downstream accepts the current word |
| out_valid | output | 1 | A readout word is presented |
| out_last | output | 1 | The presented word is the trailer |
| out_word | output | 23 | Hit word or trailer word |
| busy | output | 1 | Readout in progress; recording is frozen |

## Verification
The assertions assume that `hit_in` pulses on a given channel are spaced far enough apart for the previous hit to have been written before the next edge arrives. They also assume that `fine_in` is steady while an edge crosses the synchroniser. The stimulus meets both assumptions: `fine_in` is set well before each pulse and held, and repeated pulses on one channel are at least eight cycles apart. Triggers are only raised after every pending hit has drained into the buffer, so each event's contents are fully determined when the readout starts.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int NCH = 24;
  localparam int FW  = 5;
  localparam int TW  = 17;
  localparam int CHW = 5;
  localparam int CW  = TW - FW;
  localparam int WW  = 1 + CHW + TW;

  typedef struct packed {
    logic           ovf;
    logic [CHW-1:0] chan;
    logic [TW-1:0]  stamp;
  } hit_word_t;
endpackage

// File: rtl/tdc_edge_sync.sv
module tdc_edge_sync #(
  parameter int N = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw_in,
  output logic [N-1:0] rise
);
  logic [N-1:0] s1_q, s2_q, s3_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
      s3_q <= '0;
    end else begin
      s1_q <= raw_in;
      s2_q <= s1_q;
      s3_q <= s2_q;
    end
  end

  assign rise = s2_q & ~s3_q;
endmodule

// File: rtl/tdc_hit_arbiter.sv
module tdc_hit_arbiter import tdc_pkg::*; #(
  parameter int HITCAP = 16,
  localparam int CAPW = $clog2(HITCAP + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              hold,
  input  logic              clear_evt,
  input  logic [NCH-1:0]    rise,
  input  logic [NCH*FW-1:0] fine_in,
  input  logic [CW-1:0]     coarse,
  output logic              push,
  output hit_word_t         push_word
);
  logic [NCH-1:0] pend_q, pend_d, capt, grant;
  logic [TW-1:0]  stamp_q [NCH];
  logic [CAPW-1:0] cnt_q  [NCH];
  logic [CHW-1:0] gidx;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign capt[c] = rise[c] & enable & ~hold & ~pend_q[c]
                     & (cnt_q[c] < CAPW'(HITCAP));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stamp_q[c] <= '0;
      end else if (capt[c]) begin
        stamp_q[c] <= {coarse, fine_in[c*FW +: FW]};
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cnt_q[c] <= '0;
      end else if (clear_evt) begin
        cnt_q[c] <= '0;
      end else if (capt[c]) begin
        cnt_q[c] <= cnt_q[c] + 1'b1;
      end
    end

    AST_CAP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q[c] <= CAPW'(HITCAP)); // R5
  end

  always_comb begin
    grant = '0;
    gidx  = '0;
    if (!hold) begin
      for (int c = NCH - 1; c >= 0; c--) begin
        if (pend_q[c]) begin
          grant = '0;
          grant[c] = 1'b1;
          gidx = CHW'(c);
        end
      end
    end
  end

  always_comb begin
    pend_d = (pend_q & ~grant) | capt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  always_comb begin
    push            = |grant;
    push_word.ovf   = 1'b0;
    push_word.chan  = gidx;
    push_word.stamp = stamp_q[gidx];
  end

  AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> ((pend_q & (grant - 1'b1)) == '0)); // R4
  AST_FROZEN_NO_PUSH: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !push); // R8
endmodule

// File: rtl/tdc_hit_buffer.sv
module tdc_hit_buffer import tdc_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      mode_fifo,
  input  logic      push,
  input  hit_word_t push_word,
  input  logic      pop,
  input  logic      clear_evt,
  output hit_word_t head,
  output logic      empty,
  output logic      ovf_sticky
);
  hit_word_t     mem [DEPTH];
  logic [AW-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [NW-1:0] fill_q, fill_d;
  logic          sticky_q, sticky_d;
  logic          full, do_wr, drop_old, refuse, adv_rd;
  hit_word_t     wr_word;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    full     = (fill_q == NW'(DEPTH));
    do_wr    = push & (~full | mode_fifo);
    drop_old = push & full & mode_fifo;
    refuse   = push & full & ~mode_fifo;
    adv_rd   = pop | drop_old;
    wr_word  = push_word;
    wr_word.ovf = full;
    wptr_d   = do_wr  ? bump(wptr_q) : wptr_q;
    rptr_d   = adv_rd ? bump(rptr_q) : rptr_q;
    fill_d   = fill_q + NW'(do_wr) - NW'(adv_rd);
    sticky_d = clear_evt ? 1'b0 : (sticky_q | refuse);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q   <= '0;
      rptr_q   <= '0;
      fill_q   <= '0;
      sticky_q <= 1'b0;
    end else begin
      wptr_q   <= wptr_d;
      rptr_q   <= rptr_d;
      fill_q   <= fill_d;
      sticky_q <= sticky_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) begin
      mem[wptr_q] <= wr_word;
    end
  end

  assign head       = mem[rptr_q];
  assign empty      = (fill_q == '0);
  assign ovf_sticky = sticky_q;

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q <= NW'(DEPTH)); // R6
  AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !mode_fifo) |=> (full && $stable(wptr_q) && $stable(rptr_q))); // R6
  AST_FIFO_STAYS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && mode_fifo) |=> full); // R7
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty); // R8
endmodule

// File: rtl/tdc_readout.sv
module tdc_readout import tdc_pkg::*; #(
  parameter int DEPTH = 256,
  localparam int NW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic [TW-1:0] window,
  input  logic [CW-1:0] coarse,
  input  logic          empty,
  input  hit_word_t     head,
  input  logic          ovf_sticky,
  input  logic          out_ready,
  output logic          pop,
  output logic          out_valid,
  output logic          out_last,
  output logic [WW-1:0] out_word,
  output logic          busy,
  output logic          clear_evt
);
  typedef enum logic [1:0] {RD_IDLE, RD_SCAN, RD_TRAIL} rd_state_t;

  rd_state_t     st_q, st_d;
  logic [TW-1:0] tref_q, tref_d, win_q, win_d;
  logic [NW-1:0] sent_q, sent_d;
  logic [TW-1:0] age;
  logic          in_win;

  always_comb begin
    st_d      = st_q;
    tref_d    = tref_q;
    win_d     = win_q;
    sent_d    = sent_q;
    pop       = 1'b0;
    out_valid = 1'b0;
    out_last  = 1'b0;
    out_word  = head;
    clear_evt = 1'b0;
    age       = tref_q - head.stamp;
    in_win    = (age <= win_q);
    case (st_q)
      RD_IDLE: begin
        if (trig) begin
          st_d   = RD_SCAN;
          tref_d = {coarse, {FW{1'b1}}};
          win_d  = window;
          sent_d = '0;
        end
      end
      RD_SCAN: begin
        if (empty) begin
          st_d = RD_TRAIL;
        end else if (in_win) begin
          out_valid = 1'b1;
          if (out_ready) begin
            pop    = 1'b1;
            sent_d = sent_q + 1'b1;
          end
        end else begin
          pop = 1'b1;
        end
      end
      default: begin
        out_valid = 1'b1;
        out_last  = 1'b1;
        out_word  = '0;
        out_word[WW-1]   = ovf_sticky;
        out_word[NW-1:0] = sent_q;
        if (out_ready) begin
          clear_evt = 1'b1;
          st_d      = RD_IDLE;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      tref_q <= '0;
      win_q  <= '0;
      sent_q <= '0;
    end else begin
      st_q   <= st_d;
      tref_q <= tref_d;
      win_q  <= win_d;
      sent_q <= sent_d;
    end
  end

  assign busy = (st_q != RD_IDLE);

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word))); // R10
  AST_TRAILER_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last && out_ready) |=> !busy); // R9
  AST_TRAILER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_last) |-> empty); // R11
endmodule

// File: rtl/tdc_hit_recorder.sv
module tdc_hit_recorder import tdc_pkg::*; #(
  parameter int DEPTH  = 256,
  parameter int HITCAP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              mode_fifo,
  input  logic [NCH-1:0]    hit_in,
  input  logic [NCH*FW-1:0] fine_in,
  input  logic              trig,
  input  logic [TW-1:0]     window,
  input  logic              out_ready,
  output logic              out_valid,
  output logic              out_last,
  output logic [WW-1:0]     out_word,
  output logic              busy
);
  logic [CW-1:0]  coarse_q;
  logic [NCH-1:0] rise;
  logic           push, pop, empty, ovf_sticky, clear_evt;
  hit_word_t      push_word, head;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      coarse_q <= '0;
    end else begin
      coarse_q <= coarse_q + 1'b1;
    end
  end

  tdc_edge_sync #(.N(NCH)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw_in(hit_in), .rise(rise)
  );

  tdc_hit_arbiter #(.HITCAP(HITCAP)) u_arb (
    .clk(clk), .rst_n(rst_n), .enable(enable), .hold(busy),
    .clear_evt(clear_evt), .rise(rise), .fine_in(fine_in),
    .coarse(coarse_q), .push(push), .push_word(push_word)
  );

  tdc_hit_buffer #(.DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n), .mode_fifo(mode_fifo), .push(push),
    .push_word(push_word), .pop(pop), .clear_evt(clear_evt),
    .head(head), .empty(empty), .ovf_sticky(ovf_sticky)
  );

  tdc_readout #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .trig(trig), .window(window),
    .coarse(coarse_q), .empty(empty), .head(head),
    .ovf_sticky(ovf_sticky), .out_ready(out_ready), .pop(pop),
    .out_valid(out_valid), .out_last(out_last), .out_word(out_word),
    .busy(busy), .clear_evt(clear_evt)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !out_valid); // R1
endmodule

// File: tb/sim_tdc_hit_recorder.sv
`timescale 1ns/1ps
module sim_tdc_hit_recorder;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         enable, mode_fifo, trig, out_ready;
  logic [23:0]  hit_in;
  logic [119:0] fine_in;
  logic [16:0]  window;
  logic         out_valid, out_last, busy;
  logic [22:0]  out_word;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [22:0] words [0:299];
  int          nwords;
  logic [22:0] trailer;

  always #2.5 clk = ~clk;

  tdc_hit_recorder u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode_fifo(mode_fifo),
    .hit_in(hit_in), .fine_in(fine_in), .trig(trig), .window(window),
    .out_ready(out_ready), .out_valid(out_valid), .out_last(out_last),
    .out_word(out_word), .busy(busy)
  );

  task automatic check(input logic ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [23:0] m);
    @(negedge clk) hit_in = m;
    @(negedge clk) hit_in = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic readout(input logic [16:0] win, input bit stall);
    bit stalled = 0;
    logic [22:0] w0;
    nwords = 0;
    @(negedge clk);
    window = win; trig = 1'b1; out_ready = 1'b1;
    @(negedge clk) trig = 1'b0;
    forever begin
      if (out_valid) begin
        if (stall && !stalled) begin
          w0 = out_word;
          out_ready = 1'b0;
          for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(out_valid && out_word == w0, "R10 stall hold", out_word, w0);
          end
          out_ready = 1'b1;
          stalled = 1;
        end
        if (out_last) begin
          trailer = out_word;
          @(negedge clk);
          break;
        end
        words[nwords] = out_word;
        nwords++;
      end
      @(negedge clk);
    end
    idle(2);
  endtask

  task automatic all_rounds();
    for (int r = 0; r < 16; r++) begin
      pulse(24'hFFFFFF);
      idle(30);
    end
    idle(10);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R1 valid low", out_valid, 0);
    check(busy == 1'b0, "R1 busy low", busy, 0);
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 0, "R1 empty count", trailer[8:0], 0);
  endtask

  task automatic t_disabled();
    enable = 1'b0;
    pulse(24'h000002);
    idle(10);
    enable = 1'b1;
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 0, "R2 disabled ignored", trailer[8:0], 0);
  endtask

  task automatic t_order();
    fine_in[2*5 +: 5]  = 5'd3;
    fine_in[9*5 +: 5]  = 5'd17;
    fine_in[20*5 +: 5] = 5'd30;
    idle(2);
    pulse(24'h100204);
    idle(20);
    readout(17'h1FFFF, 1);
    check(trailer[8:0] == 3, "R9 count 3", trailer[8:0], 3);
    check(words[0][21:17] == 2 && words[1][21:17] == 9 && words[2][21:17] == 20,
          "R4 ascending order", {words[0][21:17], words[1][21:17], words[2][21:17]}, 15'h0934);
    check(words[0][4:0] == 3 && words[1][4:0] == 17 && words[2][4:0] == 30,
          "R3 fine field", {words[0][4:0], words[1][4:0], words[2][4:0]}, {5'd3, 5'd17, 5'd30});
    check(words[1][22] == 1'b0, "R3 ovf bit clear", words[1][22], 0);
  endtask

  task automatic t_delta();
    logic [16:0] d;
    fine_in[7*5 +: 5] = 5'd11;
    idle(2);
    @(negedge clk) hit_in = 24'h000080;
    @(negedge clk) hit_in = '0;
    idle(38);
    @(negedge clk) hit_in = 24'h000080;
    @(negedge clk) hit_in = '0;
    idle(10);
    readout(17'h1FFFF, 0);
    d = words[1][16:0] - words[0][16:0];
    check(trailer[8:0] == 2, "R12 two hits", trailer[8:0], 2);
    check(d == 17'd1280, "R12 stamp delta", d, 1280);
  endtask

  task automatic t_window();
    pulse(24'h000020);
    idle(100);
    pulse(24'h000040);
    idle(20);
    readout(17'd1600, 0);
    check(trailer[8:0] == 1, "R8 window count", trailer[8:0], 1);
    check(words[0][21:17] == 6, "R8 window channel", words[0][21:17], 6);
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 0, "R8 outside discarded", trailer[8:0], 0);
  endtask

  task automatic t_cap();
    for (int i = 0; i < 20; i++) begin
      pulse(24'h000008);
      idle(6);
    end
    idle(10);
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 16, "R5 cap 16", trailer[8:0], 16);
    pulse(24'h000008);
    idle(10);
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 1, "R11 cap cleared", trailer[8:0], 1);
  endtask

  task automatic t_refuse();
    int bad = 0;
    mode_fifo = 1'b0;
    all_rounds();
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 256, "R6 refuse count", trailer[8:0], 256);
    check(trailer[22] == 1'b1, "R6 sticky flag", trailer[22], 1);
    check(words[0][21:17] == 0, "R6 oldest kept", words[0][21:17], 0);
    check(words[255][21:17] == 15, "R6 last stored", words[255][21:17], 15);
    for (int i = 0; i < 256; i++) if (words[i][22]) bad++;
    check(bad == 0, "R6 no ovf bits", bad, 0);
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 0 && trailer[22] == 1'b0, "R11 flag cleared", trailer, 0);
  endtask

  task automatic t_fifo();
    mode_fifo = 1'b1;
    all_rounds();
    readout(17'h1FFFF, 0);
    check(trailer[8:0] == 256, "R7 fifo count", trailer[8:0], 256);
    check(trailer[22] == 1'b0, "R7 no sticky", trailer[22], 0);
    check(words[0][21:17] == 8 && words[0][22] == 1'b0, "R7 oldest dropped", words[0], 8 << 17);
    check(words[127][21:17] == 15 && words[127][22] == 1'b0, "R7 last before full", words[127], 15 << 17);
    check(words[128][21:17] == 16 && words[128][22] == 1'b1, "R7 first ovf word", words[128], (1 << 22) | (16 << 17));
    check(words[255][21:17] == 23 && words[255][22] == 1'b1, "R7 newest kept", words[255], (1 << 22) | (23 << 17));
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        errors++;
        checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0; enable = 1'b0; mode_fifo = 1'b0; trig = 1'b0;
    out_ready = 1'b1; hit_in = '0; fine_in = '0; window = '0;
    idle(4);
    @(negedge clk) rst_n = 1'b1;
    idle(2);
    t_reset();
    enable = 1'b1;
    t_disabled();
    t_order();
    t_delta();
    t_window();
    t_cap();
    t_refuse();
    t_fifo();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule